// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel with six operating modes. A host loads an initial count with a one-cycle strobe, selects an operating mode and binary or four-digit decimal (BCD) counting, and then drives a gate level and a counting clock enable. The channel shows its live count and an OUT level. How OUT behaves depends on the mode: one-shot levels, one-shot strobes, a periodic rate pulse or a square wave.

Counting is measured in ticks. A tick is a clock cycle in which the counting enable is high, the gate is high, and neither a load nor a gate rising edge takes place. A load or a gate rising edge restarts the channel, and the elapsed tick count (called d below) goes back to zero. N is the effective initial count. A loaded value of zero stands for the full range of the number system.

Top module: `ivc_channel`

## Requirements
- R1: After reset the count output reads 0x0000 and OUT is low.
- R2: A load strobe stores `load_val`. On the following cycle the count output shows that value, and the elapsed tick count restarts from zero.
- R3: A loaded value of zero acts as N = 65536 in binary counting and N = 10000 in BCD counting.
- R4: In modes 0, 1, 4 and 5 the counter goes on past zero. It wraps to 0xFFFF in binary or to 0x9999 in BCD, and the visible count equals (N - d) modulo the range.
- R5: In modes 0 and 1, OUT is low while d < N. OUT is high from d = N onward until the next restart.
- R6: In mode 2, the count reloads to N instead of reaching zero, so it shows N - (d mod N). OUT is high only while d is a nonzero multiple of N.
- R7: In mode 3, OUT is high while (d mod N) < (N+1)/2 and low otherwise. The visible count drops by two per tick and reloads to N when a tick finds it at 1 or 2.
- R8: In modes 4 and 5, OUT is high only while d = N. It does not rise again before the next restart.
- R9: The count and OUT hold still in any cycle where the gate is low or the counting enable is low.
- R10: A rising edge of the gate restarts counting from the stored initial count, and d becomes zero.
- R11: In BCD counting, the count is held as four packed decimal digits with bit 3:0 as the units digit. A decrement borrows across digits from 0 to 9.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_val | input | 16 | Initial count to store |
| load_stb | input | 1 | One-cycle load strobe |
| mode | input | 3 | Operating mode 0 to 7 |
| bcd_sel | input | 1 | 1 selects BCD counting, 0 selects binary |
| gate | input | 1 | Gate level; a rising edge restarts counting |
| cnt_en | input | 1 | Counting clock enable |
| count_o | output | 16 | Live count |
| out_o | output | 1 | OUT level |

## Verification
The bench uses the default 16-bit width, which gives four decimal digits. With small initial counts, every mode reaches its expiry, reload, and wrap points within a few clocks, and counts of 1 through 7 cover both odd and even square-wave periods. The default width keeps a zero load within the cycle budget: 65536 ticks in binary and 10000 ticks in BCD. The bench therefore runs the full range end to end and checks the wrap after expiry.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int CNT_W    = 16;
  localparam int DIGITS   = CNT_W / 4;
  localparam int FULL_DEC = 10 ** DIGITS;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   eff_t;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HIT  = 2'd1,
    PH_PAST = 2'd2
  } phase_e;

  // One-step decrement, binary or packed decimal with digit borrow.
  function automatic cnt_t ivc_dec1(input cnt_t v, input logic bcd);
    cnt_t r;
    logic brw;
    if (!bcd) return v - CNT_W'(1);
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (brw) begin
        if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Numeric value of a stored count; zero means the full range.
  function automatic eff_t ivc_eff(input cnt_t v, input logic bcd);
    eff_t acc;
    if (v == '0) return bcd ? eff_t'(FULL_DEC) : (eff_t'(1) << CNT_W);
    if (!bcd) return {1'b0, v};
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * eff_t'(10) + eff_t'(v[i*4 +: 4]);
    return acc;
  endfunction

  function automatic logic ivc_bcd_ok(input cnt_t v);
    for (int i = 0; i < DIGITS; i++)
      if (v[i*4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

  AST_RISE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R10
endmodule

// File: rtl/ivc_down_ctr.sv
module ivc_down_ctr import ivc_pkg::*; #(
  parameter int STEP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic bcd,
  input  logic periodic,
  input  cnt_t init,
  output cnt_t val,
  output logic reload_evt,
  output logic hit_evt
);
  cnt_t cur_q;
  cnt_t step_nxt;
  logic reload_now;

  generate
    if (STEP == 2) begin : g_step2
      assign step_nxt = ivc_dec1(ivc_dec1(cur_q, bcd), bcd);
    end else begin : g_step1
      assign step_nxt = ivc_dec1(cur_q, bcd);
    end
  endgenerate

  assign reload_now = periodic && (ivc_eff(cur_q, bcd) <= eff_t'(STEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (restart) cur_q <= init;
    else if (tick)    cur_q <= reload_now ? init : step_nxt;
  end

  assign val        = cur_q;
  assign reload_evt = tick && !restart && reload_now;
  assign hit_evt    = tick && !restart && !reload_now && (step_nxt == '0);

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cur_q)); // R9
  AST_RESTART_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cur_q == $past(init))); // R10
  AST_BCD_STAYS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && bcd && ivc_bcd_ok(cur_q) && ivc_bcd_ok(init)) |=> ivc_bcd_ok(cur_q)); // R11
endmodule

// File: rtl/ivc_out_logic.sv
module ivc_out_logic import ivc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic       hit_evt,
  input  logic       reload_evt,
  input  logic [2:0] mode,
  input  eff_t       pos_eff,
  input  eff_t       full_eff,
  output logic       out
);
  phase_e phase_q;
  logic   pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      pulse_q <= 1'b0;
    end else if (restart) begin
      phase_q <= PH_WAIT;
      pulse_q <= 1'b0;
    end else if (tick) begin
      pulse_q <= reload_evt;
      if (phase_q == PH_WAIT && hit_evt) phase_q <= PH_HIT;
      else if (phase_q == PH_HIT)        phase_q <= PH_PAST;
    end
  end

  always_comb begin
    case (mode)
      3'd0, 3'd1: out = (phase_q != PH_WAIT);
      3'd2, 3'd6: out = pulse_q;
      3'd3, 3'd7: out = (pos_eff > (full_eff >> 1));
      default:    out = (phase_q == PH_HIT);
    endcase
  end

  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAST && !restart) |=> (phase_q == PH_PAST)); // R8
  AST_PULSE_FROM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(reload_evt)); // R6
endmodule

// File: rtl/ivc_channel.sv
module ivc_channel import ivc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_stb,
  input  logic [2:0]       mode,
  input  logic             bcd_sel,
  input  logic             gate,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  cnt_t init_q;
  cnt_t init_mux;
  cnt_t pos_val;
  cnt_t vis_val;
  logic gate_rise;
  logic restart;
  logic tick;
  logic pos_reload, pos_hit;
  logic vis_reload, vis_hit;
  logic unused_vis;
  logic sq_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        init_q <= '0;
    else if (load_stb) init_q <= load_val;
  end

  ivc_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise)
  );

  assign restart  = load_stb | gate_rise;
  assign tick     = cnt_en & gate & ~restart;
  assign init_mux = load_stb ? load_val : init_q;
  assign sq_mode  = mode[1] & mode[0];

  // Position within the period (or elapsed countdown for one-shot modes)
  ivc_down_ctr #(.STEP(1)) u_pos (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .bcd(bcd_sel), .periodic(mode[1]), .init(init_mux),
    .val(pos_val), .reload_evt(pos_reload), .hit_evt(pos_hit)
  );

  // Visible square-wave count, two per tick
  ivc_down_ctr #(.STEP(2)) u_vis (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .bcd(bcd_sel), .periodic(1'b1), .init(init_mux),
    .val(vis_val), .reload_evt(vis_reload), .hit_evt(vis_hit)
  );
  assign unused_vis = vis_reload ^ vis_hit;

  ivc_out_logic u_out (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .hit_evt(pos_hit), .reload_evt(pos_reload), .mode(mode),
    .pos_eff(ivc_eff(pos_val, bcd_sel)), .full_eff(ivc_eff(init_q, bcd_sel)),
    .out(out_o)
  );

  assign count_o = sq_mode ? vis_val : pos_val;

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (count_o == $past(load_val))); // R2
endmodule

// File: tb/ivc_channel_tb_top.sv
module ivc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] load_val;
  logic        load_stb;
  logic [2:0]  mode;
  logic        bcd_sel;
  logic        gate;
  logic        cnt_en;
  logic [15:0] count_o;
  logic        out_o;

  always #2 clk = ~clk;

  ivc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .load_val(load_val), .load_stb(load_stb),
    .mode(mode), .bcd_sel(bcd_sel), .gate(gate), .cnt_en(cnt_en),
    .count_o(count_o), .out_o(out_o)
  );

  int    n_run = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string req_tag = "R1";

  // Behavioural model: elapsed ticks d since restart, stored raw count, square-wave visible value
  logic [15:0] m_raw;
  int          m_d;
  int          m_v;
  bit          m_gp;
  bit          m_rise;

  function automatic int effv(input logic [15:0] x, input bit b);
    if (x == 16'h0) return b ? 10000 : 65536;
    if (b) return int'(x[15:12]) * 1000 + int'(x[11:8]) * 100 + int'(x[7:4]) * 10 + int'(x[3:0]);
    return int'(x);
  endfunction

  function automatic logic [15:0] enc(input int x, input bit b);
    int y;
    if (b) begin
      y = x % 10000;
      return {4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    end
    return 16'(x % 65536);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = 16'h0; m_d = 0; m_v = effv(16'h0, bcd_sel); m_gp = 1'b0;
    end else begin
      m_rise = gate && !m_gp;
      m_gp   = gate;
      if (load_stb) begin
        m_raw = load_val; m_d = 0; m_v = effv(load_val, bcd_sel);
      end else if (m_rise) begin
        m_d = 0; m_v = effv(m_raw, bcd_sel);
      end else if (cnt_en && gate) begin
        m_d++;
        m_v = (m_v <= 2) ? effv(m_raw, bcd_sel) : m_v - 2;
      end
    end
  end

  task automatic check_now();
    int          n, rng;
    logic [15:0] e_cnt;
    logic        e_out;
    n   = effv(m_raw, bcd_sel);
    rng = bcd_sel ? 10000 : 65536;
    if (mode[1] && mode[0]) begin            // R7 / R12 square wave
      e_cnt = enc(m_v, bcd_sel);
      e_out = (m_d % n) < ((n + 1) / 2);
    end else if (mode[1]) begin              // R6 / R12 rate pulse
      e_cnt = enc(n - (m_d % n), bcd_sel);
      e_out = ((m_d % n) == 0) && (m_d != 0);
    end else begin                           // R4 wrap for one-shot modes
      e_cnt = enc((((n - m_d) % rng) + rng) % rng, bcd_sel);
      e_out = mode[2] ? (m_d == n) : (m_d >= n);   // R8 : R5
    end
    n_run++;
    if (count_o !== e_cnt || out_o !== e_out) begin
      n_fail++;
      $display("FAIL %s mode=%0d d=%0d count=%h exp=%h out=%b exp=%b",
               req_tag, mode, m_d, count_o, e_cnt, out_o, e_out);
    end
  endtask

  always @(posedge clk) begin
    #1;
    check_now();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic ld(input logic [2:0] m, input logic [15:0] v, input bit b);
    @(negedge clk);
    mode = m; bcd_sel = b; load_val = v; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; load_val = 16'h0; load_stb = 1'b0; mode = 3'd0;
    bcd_sel = 1'b0; gate = 1'b1; cnt_en = 1'b0;
    req_tag = "R1";
    run(3);
    rst_n = 1'b1;
    run(2);
    if (count_o !== 16'h0 || out_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset count=%h exp=0000 out=%b exp=0", count_o, out_o);
    end
    n_run++;
    cnt_en = 1'b1;

    req_tag = "R2";  ld(3'd0, 16'd9, 1'b0); run(4);
    ld(3'd0, 16'd6, 1'b0); run(3);
    req_tag = "R5";  ld(3'd0, 16'd5, 1'b0); run(12);
    ld(3'd1, 16'd3, 1'b0); run(8);
    req_tag = "R4";  ld(3'd1, 16'd2, 1'b0); run(6);
    req_tag = "R6";  ld(3'd2, 16'd4, 1'b0); run(14);
    ld(3'd2, 16'd1, 1'b0); run(5);
    req_tag = "R7";  ld(3'd3, 16'd5, 1'b0); run(16);
    ld(3'd3, 16'd6, 1'b0); run(16);
    ld(3'd3, 16'd1, 1'b0); run(4);
    req_tag = "R8";  ld(3'd4, 16'd3, 1'b0); run(9);
    ld(3'd5, 16'd2, 1'b0); run(7);
    req_tag = "R9";  ld(3'd0, 16'd10, 1'b0);
    for (int i = 0; i < 24; i++) begin
      cnt_en = i[0];
      @(negedge clk);
    end
    cnt_en = 1'b1;
    ld(3'd2, 16'd7, 1'b0); run(3);
    gate = 1'b0; run(4);
    req_tag = "R10"; gate = 1'b1; run(12);
    gate = 1'b0; run(1); gate = 1'b1; run(1); gate = 1'b0; run(1); gate = 1'b1; run(5);
    req_tag = "R11"; ld(3'd0, 16'h0103, 1'b1); run(12);
    ld(3'd4, 16'h0002, 1'b1); run(6);
    ld(3'd3, 16'h0011, 1'b1); run(14);
    req_tag = "R12"; ld(3'd6, 16'd3, 1'b0); run(10);
    ld(3'd7, 16'd4, 1'b0); run(10);
    req_tag = "R3";  ld(3'd0, 16'h0000, 1'b0); run(65540);
    ld(3'd2, 16'h0000, 1'b1); run(10005);
    ld(3'd4, 16'h0000, 1'b1); run(10003);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule